// File: doc/BRIEF.md
# Link Receiver Width Negotiator

This block settles the width a point-to-point link uses straight after a cold reset. While reset is held it places a fixed advertisement on its transmit lanes. The advertisement states how wide its own receiver is. Each lane below the advertised width is driven high, and every other lane is driven low. The far end does the same thing towards this block.

On the first rising clock edge after reset is released, the block captures the lanes it receives. It reduces them to a three-bit width code, using the widest contiguous group of high lanes that starts at lane 0. Any advertisement wider than eight lanes counts as eight. The code is written into both the inbound and the outbound width outputs, so the two directions always come out of reset at the same width. A one-cycle completion pulse marks the capture.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level or pulse, and the block never back-pressures anything. The captured code stays fixed until the next reset.

Top module: `lwn_negotiator`

## Requirements
- R1: While `rst_n` is low, `tx_cad` drives 1 on lanes 0 up to min(RX_W, TX_W)-1 and 0 on every higher lane.
- R2: From the first rising edge with `rst_n` high onwards, `tx_cad` is all zero.
- R3: If received lanes 0 to 7 all read 1 at the capture edge, the width code is 3'b000 (8 lanes).
- R4: If received lanes 0 to 3 read 1 but lanes 0 to 7 are not all 1, the width code is 3'b101 (4 lanes).
- R5: If received lanes 0 and 1 read 1 but lanes 0 to 3 are not all 1, the width code is 3'b100 (2 lanes). If lanes 0 and 1 are not both 1, the code also falls back to 3'b100.
- R6: Received lanes 8 and above never affect the result. Lanes that the receiver does not have (index RX_W or above, up to 7) read as 0.
- R7: The received lanes are captured only on the first rising edge after `rst_n` goes high. Later changes on `rx_cad` leave the width outputs unchanged until the next reset.
- R8: `link_width_in` and `link_width_out` always carry the same code.
- R9: While `rst_n` is low, both width outputs read 3'b100 and `neg_done` is 0. `neg_done` is 1 for exactly the one cycle that follows the capture edge.
- R10: Asserting reset again and releasing it runs a fresh negotiation, with a new advertisement and a new capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link core clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous assert |
| rx_cad | input | RX_W | Receive lanes carrying the far end's advertisement |
| tx_cad | output | TX_W | Transmit lanes carrying this side's advertisement |
| link_width_in | output | 3 | Negotiated inbound width code |
| link_width_out | output | 3 | Negotiated outbound width code (same as inbound) |
| neg_done | output | 1 | One-cycle pulse after the capture edge |

## Verification
The bench builds two instances side by side, and both take the same reset.

The first has a 16-lane receiver and an 8-lane transmitter. This case shows the advertisement being cut down to the transmitter's lanes, and it shows that lanes 8 to 15 are ignored during decoding.

The second has a 4-lane receiver behind an 8-lane transmitter. This case exercises the narrower advertisement and the rule that missing receive lanes read as zero, which caps the result at 4 lanes.

// File: rtl/lwn_pkg.sv
package lwn_pkg;

  // Width codes loaded into both direction fields.
  typedef enum logic [2:0] {
    WC_8  = 3'b000,
    WC_16 = 3'b001,
    WC_32 = 3'b011,
    WC_2  = 3'b100,
    WC_4  = 3'b101
  } width_code_e;

  typedef enum logic [0:0] {
    PH_ADVERTISE = 1'b0,
    PH_RUN       = 1'b1
  } phase_e;

  // Widest lane group the reset handshake can resolve.
  localparam int unsigned HANDSHAKE_LANES = 8;

endpackage

// File: rtl/lwn_adv_gen.sv
module lwn_adv_gen #(
  parameter int unsigned TX_W = 8,
  parameter int unsigned RX_W = 8
) (
  input  logic            advertise,
  output logic [TX_W-1:0] tx_cad
);
  // Lanes carrying a one: own receiver width, limited to physical tx lanes.
  localparam int unsigned ADV_LANES = (RX_W < TX_W) ? RX_W : TX_W;

  for (genvar lane = 0; lane < TX_W; lane++) begin : g_lane
    if (lane < ADV_LANES) begin : g_on
      assign tx_cad[lane] = advertise;
    end else begin : g_off
      assign tx_cad[lane] = 1'b0;
    end
  end

endmodule

// File: rtl/lwn_decoder.sv
module lwn_decoder
  import lwn_pkg::*;
#(
  parameter int unsigned RX_W = 8
) (
  input  logic [RX_W-1:0] rx_cad,
  output width_code_e     code
);
  localparam int unsigned SEEN = (RX_W < HANDSHAKE_LANES) ? RX_W : HANDSHAKE_LANES;

  logic [HANDSHAKE_LANES-1:0] low_lanes;

  // Lanes the receiver lacks read as zero; lanes above the handshake range are dropped.
  for (genvar lane = 0; lane < HANDSHAKE_LANES; lane++) begin : g_low
    if (lane < SEEN) begin : g_have
      assign low_lanes[lane] = rx_cad[lane];
    end else begin : g_tie
      assign low_lanes[lane] = 1'b0;
    end
  end

  if (RX_W > HANDSHAKE_LANES) begin : g_unused
    logic upper_unused;
    assign upper_unused = |rx_cad[RX_W-1:HANDSHAKE_LANES];
  end

  always_comb begin
    if (&low_lanes)            code = WC_8;
    else if (&low_lanes[3:0])  code = WC_4;
    else                       code = WC_2;
  end

endmodule

// File: rtl/lwn_capture.sv
module lwn_capture
  import lwn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  width_code_e next_code,
  output phase_e      phase,
  output width_code_e code_q,
  output logic        done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ADVERTISE;
      code_q <= WC_2;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_ADVERTISE) begin
        phase  <= PH_RUN;
        code_q <= next_code;
        done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lwn_negotiator.sv
module lwn_negotiator
  import lwn_pkg::*;
#(
  parameter int unsigned TX_W = 8,
  parameter int unsigned RX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RX_W-1:0] rx_cad,
  output logic [TX_W-1:0] tx_cad,
  output logic [2:0]      link_width_in,
  output logic [2:0]      link_width_out,
  output logic            neg_done
);
  phase_e      phase;
  width_code_e next_code;
  width_code_e code_q;

  lwn_adv_gen #(.TX_W(TX_W), .RX_W(RX_W)) u_adv (
    .advertise (phase == PH_ADVERTISE),
    .tx_cad    (tx_cad)
  );

  lwn_decoder #(.RX_W(RX_W)) u_dec (
    .rx_cad (rx_cad),
    .code   (next_code)
  );

  lwn_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .next_code (next_code),
    .phase     (phase),
    .code_q    (code_q),
    .done      (neg_done)
  );

  assign link_width_in  = code_q;
  assign link_width_out = code_q;

endmodule

// File: rtl/lwn_negotiator_chk.sv
module lwn_negotiator_chk #(
  parameter int unsigned TX_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TX_W-1:0] tx_cad,
  input logic [2:0]      link_width_in,
  input logic [2:0]      link_width_out,
  input logic            neg_done
);
  logic       seen;
  logic [1:0] done_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      done_cnt <= 2'd0;
    end else begin
      seen <= 1'b1;
      if (neg_done && done_cnt != 2'd3) done_cnt <= done_cnt + 2'd1;
    end
  end

  assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (tx_cad == '0));

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_width_in inside {3'b000, 3'b101, 3'b100});

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !neg_done) |-> $stable(link_width_in));

  assert_dirs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_width_in == link_width_out);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    neg_done |=> !neg_done);

  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_cnt <= 2'd1);

endmodule

bind lwn_negotiator lwn_negotiator_chk #(.TX_W(TX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_cad         (tx_cad),
  .link_width_in  (link_width_in),
  .link_width_out (link_width_out),
  .neg_done       (neg_done)
);

// File: tb/sim_lwn_negotiator.sv
module sim_lwn_negotiator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx0 = '0;
  logic [3:0]  rx1 = '0;
  logic [7:0]  tx0, tx1;
  logic [2:0]  win0, wout0, win1, wout1;
  logic        done0, done1;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  lwn_negotiator #(.TX_W(8), .RX_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_cad(rx0), .tx_cad(tx0),
    .link_width_in(win0), .link_width_out(wout0), .neg_done(done0));

  lwn_negotiator #(.TX_W(8), .RX_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_cad(rx1), .tx_cad(tx1),
    .link_width_in(win1), .link_width_out(wout1), .neg_done(done1));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Width code from the lanes 0..7 as seen by the receiver (R3, R4, R5).
  function automatic int exp_code(input logic [7:0] v);
    if (v == 8'hff) return 3'b000;
    if (v[3:0] == 4'hf) return 3'b101;
    return 3'b100;
  endfunction

  // Hold reset, check the advertisement and reset outputs (R1, R9).
  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "u0 advert", tx0, 8'hff);
    check("R1", "u1 advert", tx1, 8'h0f);
    check("R9", "u0 width in reset", win0, 3'b100);
    check("R9", "u0 done in reset", done0, 0);
    check("R9", "u1 width in reset", win1, 3'b100);
  endtask

  // Full negotiation with given receive patterns (R2..R10).
  task automatic t_negotiate(input logic [15:0] p0, input logic [3:0] p1, input string tag);
    int e0, e1;
    t_reset_state();
    rx0 = p0; rx1 = p1;
    e0 = exp_code(p0[7:0]);
    e1 = exp_code({4'b0000, p1});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9", {tag, " u0 done pulse"}, done0, 1);
    check("R9", {tag, " u1 done pulse"}, done1, 1);
    check("R3", {tag, " u0 code (R4 R5 R6)"}, win0, e0);
    check("R6", {tag, " u1 code (R4 R5)"}, win1, e1);
    check("R8", {tag, " u0 out dir"}, wout0, e0);
    check("R8", {tag, " u1 out dir"}, wout1, e1);
    check("R2", {tag, " u0 tx quiet"}, tx0, 0);
    check("R2", {tag, " u1 tx quiet"}, tx1, 0);
    rx0 = ~p0; rx1 = ~p1;
    @(negedge clk);
    check("R9", {tag, " u0 done drop"}, done0, 0);
    repeat (3) @(negedge clk);
    check("R7", {tag, " u0 hold"}, win0, e0);
    check("R7", {tag, " u1 hold"}, win1, e1);
  endtask

  initial begin
    t_negotiate(16'hffff, 4'hf, "R3 full");
    t_negotiate(16'hff0f, 4'h3, "R4 quad");
    t_negotiate(16'h0003, 4'h0, "R5 pair");
    t_negotiate(16'h00f3, 4'h7, "R5 broken");
    t_negotiate(16'h007f, 4'he, "R4 seven");
    t_negotiate(16'hff00, 4'hb, "R6 upper");
    // R10: a second run after a different one yields the new result.
    t_negotiate(16'h00ff, 4'hf, "R10 rerun");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule